// File: doc/BRIEF.md
# Serial Port Control Register Core

This block is the register-side control core of a small serial port. It sits on a byte-wide memory-mapped bus with a 64-byte address window. Software configures two mode bytes, issues packed command bytes that enable or disable the transmit and receive directions, and loads bytes for transmission into a single holding register. The bit-level shifter, the baud generator and the receive FIFO storage sit outside this block. The FIFO reports its occupancy through two status inputs, and the block tells it to empty itself through a one-cycle pulse.

The two mode bytes share one address. A pointer selects which one is accessed. Any write to that address moves the pointer to the second byte, and only a command can return it to the first. A command byte carries three fields that act in a fixed order within one write: a miscellaneous action first, then the transmitter field, then the receiver field. So a "reset transmitter" and an "enable transmitter" in the same byte leave the transmitter enabled with its holding register empty.

A held byte leaves through a valid/ready byte port while the transmitter is enabled. Reads are combinational on the address. No read has a side effect.

Top module: `uart_ctrl_core`

## Requirements
- R1: Synchronous reset clears both mode bytes and the mode pointer, disables both directions, and discards any held byte. After reset, status reads 0x08 and offset 0x00 reads 0x00.
- R2: A write to offset 0x00 stores the data into the mode byte the pointer selects, then points at the second byte. A read of offset 0x00 returns the selected byte.
- R3: A command (offset 0x08) whose bits [6:4] equal 1 returns the mode pointer to the first byte.
- R4: A command whose bits [6:4] equal 2 disables the receiver and raises `rx_flush` for exactly the cycle after the write.
- R5: A command whose bits [6:4] equal 3 disables the transmitter and discards the held byte, so TxEMP (status bit 3) is set and TxRDY (status bit 2) is cleared.
- R6: A command whose bits [6:4] equal 5 raises `brk_clr` for exactly the cycle after the write. The values 0, 4, 6 and 7 change nothing.
- R7: Command bits [3:2] set the transmitter and bits [1:0] set the receiver, with the same encoding in both: 1 enables, 2 disables, and 0 and 3 leave the enable unchanged.
- R8: Within one command, the miscellaneous field acts first, then the transmitter field, then the receiver field. For example, 0x34 leaves the transmitter enabled with nothing held, and 0x21 leaves the receiver enabled while still pulsing `rx_flush`.
- R9: A write to offset 0x0C loads the holding register and clears TxEMP. While the transmitter is enabled, `tx_valid` is high with the byte on `tx_data`. The cycle after `tx_ready` is seen, TxEMP is set again.
- R10: TxRDY (status bit 2) is high exactly when the transmitter is enabled.
- R11: While a byte is held and not yet accepted, `tx_valid` and `tx_data` stay stable. A new write to 0x0C replaces the held byte. A byte held while the transmitter is disabled is kept and offered once it is enabled again.
- R12: Status (offset 0x04) reads {4'b0, TxEMP, TxRDY, `rx_full`, `rx_avail`}, so bit 0 is receive-ready and bit 1 is FIFO-full. Writes to 0x04 change nothing.
- R13: Offsets 0x08, 0x0C and every unmapped offset read 0x00. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one bus cycle |
| bus_addr | input | ADDR_W (6) | Byte offset in the window |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data, combinational on `bus_addr` |
| tx_valid | output | 1 | Held byte offered to the shifter |
| tx_ready | input | 1 | Shifter accepts the offered byte |
| tx_data | output | DATA_W (8) | Held byte |
| rx_avail | input | 1 | Receive FIFO is not empty |
| rx_full | input | 1 | Receive FIFO is full |
| rx_en | output | 1 | Receiver enabled |
| rx_flush | output | 1 | One-cycle request to empty the receive FIFO |
| brk_clr | output | 1 | One-cycle request to clear the break-change flag |

## Verification
The bench targets combined command bytes. In these, a design that applied the fields in the wrong order would leave the transmitter off after 0x34, or the receiver off after 0x21. It also targets reserved field values, which a careless decode would treat as a disable. It stalls the output port and rewrites the holding register, which catches a design that drops or corrupts the held byte, and disables the transmitter with a byte pending, which catches a design that loses that byte. It also checks the mode pointer's sticky advance and its command reset, and confirms that writes to status and unmapped offsets leave every readable value unchanged.

// File: rtl/ucc_pkg.sv
package ucc_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 6;
    localparam int CMD_W      = 7;
    localparam int NUM_MODE   = 2;
    localparam int MODE_PTR_W = 1;

    // register offsets inside the window
    localparam int OFS_MODE = 'h00;
    localparam int OFS_STAT = 'h04;
    localparam int OFS_CMD  = 'h08;
    localparam int OFS_TXB  = 'h0C;

    // status bit positions
    localparam int ST_RXRDY = 0;
    localparam int ST_FULL  = 1;
    localparam int ST_TXRDY = 2;
    localparam int ST_TXEMP = 3;

    typedef enum logic [2:0] {
        MISC_NOP     = 3'd0,
        MISC_PTR_RST = 3'd1,
        MISC_RX_RST  = 3'd2,
        MISC_TX_RST  = 3'd3,
        MISC_ERR_RST = 3'd4,
        MISC_BRK_CLR = 3'd5,
        MISC_BRK_ON  = 3'd6,
        MISC_BRK_OFF = 3'd7
    } misc_e;

    typedef enum logic [1:0] {
        DIR_KEEP = 2'd0,
        DIR_ON   = 2'd1,
        DIR_OFF  = 2'd2,
        DIR_RSVD = 2'd3
    } dir_e;

    typedef struct packed {
        misc_e misc;
        dir_e  tx;
        dir_e  rx;
    } cmd_t;

    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic brk_clr;
        dir_e tx_dir;
        dir_e rx_dir;
    } act_t;

    function automatic logic apply_dir(dir_e d, logic cur);
        case (d)
            DIR_ON:  return 1'b1;
            DIR_OFF: return 1'b0;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/ucc_cmd_decode.sv
module ucc_cmd_decode
    import ucc_pkg::*;
(
    input  logic             fire,
    input  logic [CMD_W-1:0] raw,
    output act_t             act
);

    cmd_t c;
    assign c = cmd_t'(raw);

    always_comb begin
        act = '0;
        if (fire) begin
            case (c.misc)
                MISC_PTR_RST: act.ptr_rst = 1'b1;
                MISC_RX_RST:  act.rx_rst  = 1'b1;
                MISC_TX_RST:  act.tx_rst  = 1'b1;
                MISC_BRK_CLR: act.brk_clr = 1'b1;
                default:      ;
            endcase
            act.tx_dir = c.tx;
            act.rx_dir = c.rx;
        end
    end

endmodule

// File: rtl/ucc_mode_regs.sv
module ucc_mode_regs
    import ucc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  ptr_rst,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    output logic [MODE_PTR_W-1:0] ptr
);

    localparam logic [MODE_PTR_W-1:0] LAST = MODE_PTR_W'(NUM_MODE - 1);

    logic [DW-1:0]         regs [NUM_MODE];
    logic [MODE_PTR_W-1:0] ptr_q;

    for (genvar i = 0; i < NUM_MODE; i++) begin : g_mode
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (wr_en && ptr_q == MODE_PTR_W'(i))
                regs[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (wr_en)
            ptr_q <= LAST;
        else if (ptr_rst)
            ptr_q <= '0;
    end

    assign rdata = regs[ptr_q];
    assign ptr   = ptr_q;

endmodule

// File: rtl/ucc_tx_hold.sv
module ucc_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          drop,
    input  logic          en,
    input  logic [DW-1:0] wdata,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          empty
);

    logic          pend_q;
    logic [DW-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            byte_q <= '0;
        end else if (drop) begin
            pend_q <= 1'b0;
        end else if (load) begin
            pend_q <= 1'b1;
            byte_q <= wdata;
        end else if (tx_valid && tx_ready) begin
            pend_q <= 1'b0;
        end
    end

    assign tx_valid = pend_q && en;
    assign tx_data  = byte_q;
    assign empty    = !pend_q;

endmodule

// File: rtl/uart_ctrl_core.sv
module uart_ctrl_core
    import ucc_pkg::*;
#(
    parameter int ADDR_W = ucc_pkg::ADDR_W,
    parameter int DATA_W = ucc_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_avail,
    input  logic              rx_full,
    output logic              rx_en,
    output logic              rx_flush,
    output logic              brk_clr
);

    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_TXB  = ADDR_W'(OFS_TXB);

    logic wr_mode, wr_cmd, wr_txb;
    assign wr_mode = bus_we && bus_addr == A_MODE;
    assign wr_cmd  = bus_we && bus_addr == A_CMD;
    assign wr_txb  = bus_we && bus_addr == A_TXB;

    act_t act;
    ucc_cmd_decode u_dec (
        .fire (wr_cmd),
        .raw  (bus_wdata[CMD_W-1:0]),
        .act  (act)
    );

    logic [DATA_W-1:0]     mode_rdata;
    logic [MODE_PTR_W-1:0] mode_ptr;
    ucc_mode_regs #(.DW(DATA_W)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_mode),
        .ptr_rst (act.ptr_rst),
        .wdata   (bus_wdata),
        .rdata   (mode_rdata),
        .ptr     (mode_ptr)
    );

    // enables: miscellaneous reset first, then the direction fields
    logic tx_en_q, rx_en_q, rx_flush_q, brk_clr_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en_q    <= 1'b0;
            rx_en_q    <= 1'b0;
            rx_flush_q <= 1'b0;
            brk_clr_q  <= 1'b0;
        end else begin
            tx_en_q    <= apply_dir(act.tx_dir, act.tx_rst ? 1'b0 : tx_en_q);
            rx_en_q    <= apply_dir(act.rx_dir, act.rx_rst ? 1'b0 : rx_en_q);
            rx_flush_q <= act.rx_rst;
            brk_clr_q  <= act.brk_clr;
        end
    end

    logic tx_empty;
    ucc_tx_hold #(.DW(DATA_W)) u_txh (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_txb),
        .drop     (act.tx_rst),
        .en       (tx_en_q),
        .wdata    (bus_wdata),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .empty    (tx_empty)
    );

    logic [DATA_W-1:0] status;
    always_comb begin
        status           = '0;
        status[ST_RXRDY] = rx_avail;
        status[ST_FULL]  = rx_full;
        status[ST_TXRDY] = tx_en_q;
        status[ST_TXEMP] = tx_empty;
    end

    always_comb begin
        case (bus_addr)
            A_MODE:  bus_rdata = mode_rdata;
            A_STAT:  bus_rdata = status;
            default: bus_rdata = '0;
        endcase
    end

    assign rx_en    = rx_en_q;
    assign rx_flush = rx_flush_q;
    assign brk_clr  = brk_clr_q;

endmodule

// File: rtl/ucc_checker.sv
module ucc_checker
    import ucc_pkg::*;
#(
    parameter int ADDR_W = ucc_pkg::ADDR_W,
    parameter int DATA_W = ucc_pkg::DATA_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic                  tx_valid,
    input logic                  tx_ready,
    input logic [DATA_W-1:0]     tx_data,
    input logic                  rx_en,
    input logic                  rx_flush,
    input logic                  tx_en,
    input logic                  tx_empty,
    input logic [MODE_PTR_W-1:0] mode_ptr
);

    logic is_cmd, unmapped;
    assign is_cmd   = bus_we && bus_addr == ADDR_W'(OFS_CMD);
    assign unmapped = bus_addr != ADDR_W'(OFS_MODE) && bus_addr != ADDR_W'(OFS_STAT);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!tx_valid && !rx_en && !tx_en && tx_empty && mode_ptr == '0));

    a_r2_ptr_advance: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(OFS_MODE)) |=> mode_ptr == MODE_PTR_W'(1));

    a_r3_ptr_reset: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && bus_wdata[6:4] == 3'd1) |=> mode_ptr == '0);

    a_r4_flush_pulse: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && bus_wdata[6:4] == 3'd2) |=> rx_flush);

    a_r7_tx_reserved: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && bus_wdata[3:2] == 2'd3 && bus_wdata[6:4] != 3'd3) |=> $stable(tx_en));

    a_r8_order: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && bus_wdata[6:4] == 3'd3 && bus_wdata[3:2] == 2'd1) |=> (tx_en && tx_empty));

    a_r9_valid_not_empty: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !tx_empty);

    a_r11_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !bus_we) |=> (tx_valid && $stable(tx_data)));

    a_r13_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> bus_rdata == '0);

endmodule

bind uart_ctrl_core ucc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .rx_en     (rx_en),
    .rx_flush  (rx_flush),
    .tx_en     (tx_en_q),
    .tx_empty  (tx_empty),
    .mode_ptr  (mode_ptr)
);

// File: tb/sim_uart_ctrl_core.sv
`timescale 1ns/1ps
module sim_uart_ctrl_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tx_valid, tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic       rx_avail = 1'b0, rx_full = 1'b0;
    logic       rx_en, rx_flush, brk_clr;

    always #10 clk = ~clk;

    uart_ctrl_core u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .rx_avail(rx_avail),
        .rx_full(rx_full), .rx_en(rx_en), .rx_flush(rx_flush), .brk_clr(brk_clr)
    );

    int nchk = 0, nfail = 0;
    bit started = 0, done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [7:0] m_mr [2];
    int         m_ptr;
    bit         m_txen, m_rxen, m_pend, m_flush, m_brk;
    logic [7:0] m_buf;

    always @(posedge clk) begin
        bit acc;
        if (rst) begin
            m_mr[0] = 0; m_mr[1] = 0; m_ptr = 0;
            m_txen = 0; m_rxen = 0; m_pend = 0; m_buf = 0;
            m_flush = 0; m_brk = 0;
        end else begin
            acc = m_pend && m_txen && tx_ready;
            m_flush = 0; m_brk = 0;
            if (acc) m_pend = 0;
            if (bus_we) begin
                case (bus_addr)
                    6'h00: begin m_mr[m_ptr] = bus_wdata; m_ptr = 1; end
                    6'h08: begin
                        case (bus_wdata[6:4])
                            3'd1: m_ptr = 0;
                            3'd2: begin m_rxen = 0; m_flush = 1; end
                            3'd3: begin m_txen = 0; m_pend = 0; end
                            3'd5: m_brk = 1;
                            default: ;
                        endcase
                        if (bus_wdata[3:2] == 2'd1) m_txen = 1;
                        else if (bus_wdata[3:2] == 2'd2) m_txen = 0;
                        if (bus_wdata[1:0] == 2'd1) m_rxen = 1;
                        else if (bus_wdata[1:0] == 2'd2) m_rxen = 0;
                    end
                    6'h0C: begin m_buf = bus_wdata; m_pend = 1; end
                    default: ;
                endcase
            end
        end
        started = 1;
    end

    function automatic logic [7:0] m_rd(input logic [5:0] a);
        case (a)
            6'h00:   return m_mr[m_ptr];
            6'h04:   return {4'b0, !m_pend, m_txen, rx_full, rx_avail};
            default: return 8'h00;
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) if (started && !done) begin
        chk(tx_valid == (m_pend && m_txen), "R9 tx_valid model", tx_valid, m_pend && m_txen);
        if (tx_valid) chk(tx_data == m_buf, "R11 tx_data model", tx_data, m_buf);
        chk(rx_en == m_rxen, "R7 rx_en model", rx_en, m_rxen);
        chk(rx_flush == m_flush, "R4 rx_flush model", rx_flush, m_flush);
        chk(brk_clr == m_brk, "R6 brk_clr model", brk_clr, m_brk);
        chk(bus_rdata == m_rd(bus_addr),
            bus_addr == 6'h00 ? "R2 mode read model" :
            bus_addr == 6'h04 ? "R12 status read model" : "R13 zero read model",
            bus_rdata, m_rd(bus_addr));
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        #2; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; #1;
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        #2 rst = 0;
        @(negedge clk);
        rd(6'h04, 8'h08, "R1 status after reset");
        rd(6'h00, 8'h00, "R1 mode after reset");
        chk(!tx_valid && !rx_en, "R1 outputs idle", tx_valid, 0);

        // mode pointer
        wr(6'h00, 8'hA5); wr(6'h00, 8'h3C);
        rd(6'h00, 8'h3C, "R2 second mode byte");
        wr(6'h00, 8'hC3);
        rd(6'h00, 8'hC3, "R2 pointer stays on second");
        wr(6'h08, 8'h10);
        rd(6'h00, 8'hA5, "R3 pointer back to first");

        // transmit path
        tx_ready = 0;
        wr(6'h08, 8'h04);
        rd(6'h04, 8'h0C, "R10 TxRDY with enable");
        wr(6'h0C, 8'h55);
        chk(tx_valid && tx_data == 8'h55, "R9 byte offered", tx_data, 8'h55);
        rd(6'h04, 8'h04, "R9 TxEMP clear while held");
        wr(6'h0C, 8'h66);
        chk(tx_data == 8'h66, "R11 overwrite while stalled", tx_data, 8'h66);
        idle();
        chk(tx_valid && tx_data == 8'h66, "R11 stable while stalled", tx_data, 8'h66);
        #2 tx_ready = 1;
        idle();
        chk(!tx_valid, "R9 accepted", tx_valid, 0);
        rd(6'h04, 8'h0C, "R9 TxEMP set after accept");
        #2 tx_ready = 0;
        wr(6'h0C, 8'h77); wr(6'h08, 8'h08);
        chk(!tx_valid, "R11 disabled hides byte", tx_valid, 0);
        rd(6'h04, 8'h00, "R10 TxRDY off, byte kept");
        wr(6'h08, 8'h04);
        chk(tx_valid && tx_data == 8'h77, "R11 byte offered after re-enable", tx_data, 8'h77);
        wr(6'h08, 8'h34);
        chk(!tx_valid, "R8 misc reset then enable", tx_valid, 0);
        rd(6'h04, 8'h0C, "R8 tx enabled and empty");
        wr(6'h0C, 8'h12); wr(6'h08, 8'h30);
        rd(6'h04, 8'h08, "R5 transmitter reset");
        wr(6'h08, 8'h04); wr(6'h08, 8'h0C);
        rd(6'h04, 8'h0C, "R7 tx reserved keeps enable");
        wr(6'h08, 8'h08);
        rd(6'h04, 8'h08, "R7 tx disable");

        // receiver
        wr(6'h08, 8'h01); chk(rx_en, "R7 rx enable", rx_en, 1);
        wr(6'h08, 8'h03); chk(rx_en, "R7 rx reserved keeps enable", rx_en, 1);
        wr(6'h08, 8'h02); chk(!rx_en, "R7 rx disable", rx_en, 0);
        wr(6'h08, 8'h21);
        chk(rx_en && rx_flush, "R8 rx reset then enable", {rx_en, rx_flush}, 3);
        idle(); chk(!rx_flush, "R4 flush one cycle", rx_flush, 0);
        wr(6'h08, 8'h01); wr(6'h08, 8'h20);
        chk(!rx_en && rx_flush, "R4 receiver reset", {rx_en, rx_flush}, 1);

        // break clear and no-effect codes
        wr(6'h08, 8'h50); chk(brk_clr, "R6 break clear pulse", brk_clr, 1);
        idle(); chk(!brk_clr, "R6 break clear one cycle", brk_clr, 0);
        wr(6'h08, 8'h40); wr(6'h08, 8'h60); wr(6'h08, 8'h70); wr(6'h08, 8'h00);
        chk(!brk_clr && !rx_flush && !rx_en, "R6 no-effect codes", {brk_clr, rx_flush, rx_en}, 0);
        rd(6'h04, 8'h08, "R6 status unchanged");
        rd(6'h00, 8'hA5, "R6 pointer unchanged");

        // status
        wr(6'h04, 8'hFF);
        rd(6'h04, 8'h08, "R12 status write ignored");
        #2 rx_avail = 1; rx_full = 1;
        rd(6'h04, 8'h0B, "R12 receive bits");
        idle(); #2 rx_avail = 0; rx_full = 0;

        // unmapped
        wr(6'h10, 8'hFF); wr(6'h3C, 8'hFF); wr(6'h14, 8'hFF);
        rd(6'h00, 8'hA5, "R13 mode untouched");
        rd(6'h04, 8'h08, "R13 status untouched");
        rd(6'h10, 8'h00, "R13 zero at 0x10");
        rd(6'h3F, 8'h00, "R13 zero at 0x3F");
        rd(6'h08, 8'h00, "R13 command reads zero");
        rd(6'h0C, 8'h00, "R13 tx buffer reads zero");

        // reset mid-run
        wr(6'h00, 8'h99); wr(6'h08, 8'h05);
        #2 rst = 1; idle(); idle(); #2 rst = 0; idle();
        rd(6'h04, 8'h08, "R1 status after second reset");
        rd(6'h00, 8'h00, "R1 mode after second reset");
        chk(!rx_en && !tx_valid, "R1 enables after second reset", rx_en, 0);
        idle();
        summary();
    end

endmodule